// File: doc/BRIEF.md
# Priority-Ordered Pin Routing Crossbar

This block connects the signals of four internal peripherals to a bank of 32 device pins. Each peripheral has its own enable, and each pin has a skip bit. The crossbar visits the pins from index 0 upward and passes over skipped pins. It gives each pin it reaches to the next enabled peripheral signal in a fixed priority list. Any pin that is not given out stays under the GPIO output and output-enable registers. A global enable gates the whole block.

The mapping is computed combinationally from a registered copy of the configuration. A configuration change therefore moves pins one clock after it is presented. Enabling, disabling or widening one peripheral moves every peripheral of lower priority to the next free pins. Setting a skip bit in advance keeps a pin free for a signal that may be added later, without moving anything else.

Top module: `pin_xbar`

## Requirements
- R1: While reset is asserted, and at any time the registered global enable is 0, every pin has output enable 0, pad output 0 and claimed flag 0, whatever the GPIO registers hold. In the same conditions the peripheral inputs read their idle values: 0 for MISO and 1 for each UART RX.
- R2: When the global enable is 1 and no peripheral is enabled, every pin copies its GPIO output value to its pad output and its GPIO output enable to its pad output enable.
- R3: Pins are claimed in ascending index order. A pin whose skip bit is 1 is never claimed. The claimed pins are always the lowest-indexed non-skipped pins.
- R4: Signals are placed in this fixed order: SPI SCK, MOSI, MISO; then PWM channels 0 to 3; then UART0 TX, RX; then UART1 TX, RX. All signals of a disabled peripheral are left out of the order.
- R5: When SPI 4-wire mode is set together with the SPI enable, the slave-select output is placed directly after MISO. Every lower-priority signal moves up by one claimed pin.
- R6: A claimed pin carrying an output signal (SCK, MOSI, slave select, a PWM channel, a UART TX) has output enable 1 and carries the peripheral's data. A claimed pin carrying an input signal (MISO, a UART RX) has output enable 0 and pad output 0, and its pad input value is delivered to that peripheral input.
- R7: If the non-skipped pins run out before all enabled signals are placed, the signals that are left over are not connected. A left-over MISO reads 0 and a left-over UART RX reads 1.
- R8: When the global enable is 1, every unclaimed pin follows the GPIO output and GPIO output-enable registers.
- R9: The configuration inputs (global enable, peripheral enables, SPI mode, skip mask) take effect on the rising clock edge after they are presented. Reset clears the registered copy to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xbar_en | input | 1 | Global crossbar enable |
| cfg_spi_en | input | 1 | SPI peripheral enable |
| cfg_spi_4w | input | 1 | SPI 4-wire mode (adds slave select) |
| cfg_pwm_en | input | 1 | PWM/capture unit enable |
| cfg_u0_en | input | 1 | UART0 enable |
| cfg_u1_en | input | 1 | UART1 enable |
| cfg_skip | input | 32 | Per-pin skip mask |
| gpio_out | input | 32 | GPIO output values |
| gpio_oe | input | 32 | GPIO output enables |
| pad_in | input | 32 | Pad input values |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pin_claimed | output | 32 | Pin is owned by a peripheral signal |
| spi_sck | input | 1 | SPI clock from peripheral |
| spi_mosi | input | 1 | SPI MOSI from peripheral |
| spi_nss | input | 1 | SPI slave select from peripheral |
| spi_miso | output | 1 | SPI MISO to peripheral |
| pwm_out | input | 4 | PWM channel outputs from peripheral |
| u0_tx | input | 1 | UART0 TX from peripheral |
| u0_rx | output | 1 | UART0 RX to peripheral |
| u1_tx | input | 1 | UART1 TX from peripheral |
| u1_rx | output | 1 | UART1 RX to peripheral |

## Verification
The bench goes after skip masks that split a peripheral across gaps, such as skipped pins in the middle of the PWM group. A design that counted pins rather than non-skipped pins would place signals on skipped pins or leave holes. Turning 4-wire mode on and off while every peripheral is enabled checks that all lower signals move by exactly one pin; an off-by-one there puts UART TX on an RX pin. Nearly full skip masks check that leftover RX inputs read 1, where a faulty design would read a stale or floating pin. Configuration changes sampled before and after the clock edge expose a design that uses the configuration without registering it.

// File: rtl/pin_xbar.sv
module pin_xbar #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_xbar_en,
  input  logic            cfg_spi_en,
  input  logic            cfg_spi_4w,
  input  logic            cfg_pwm_en,
  input  logic            cfg_u0_en,
  input  logic            cfg_u1_en,
  input  logic [NPIN-1:0] cfg_skip,
  input  logic [NPIN-1:0] gpio_out,
  input  logic [NPIN-1:0] gpio_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pin_claimed,
  input  logic            spi_sck,
  input  logic            spi_mosi,
  input  logic            spi_nss,
  output logic            spi_miso,
  input  logic [3:0]      pwm_out,
  input  logic            u0_tx,
  output logic            u0_rx,
  input  logic            u1_tx,
  output logic            u1_rx
);
  localparam int NSIG = 12;
  localparam logic [3:0] NONE    = 4'hF;
  localparam logic [3:0] SIG_MISO = 4'd2;
  localparam logic [3:0] SIG_U0RX = 4'd9;
  localparam logic [3:0] SIG_U1RX = 4'd11;
  localparam logic [15:0] IS_OUT = 16'b0000_0101_1111_1011;

  logic            xen_q, spi_q, s4w_q, pwm_q, u0_q, u1_q;
  logic [NPIN-1:0] skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {xen_q, spi_q, s4w_q, pwm_q, u0_q, u1_q} <= '0;
      skip_q <= '0;
    end else begin
      {xen_q, spi_q, s4w_q, pwm_q, u0_q, u1_q} <=
        {cfg_xbar_en, cfg_spi_en, cfg_spi_4w, cfg_pwm_en, cfg_u0_en, cfg_u1_en};
      skip_q <= cfg_skip;
    end
  end

  logic [NSIG-1:0] act;
  logic [15:0]     drv;
  logic [3:0]      sel [NPIN];

  assign act = {NSIG{xen_q}} & {u1_q, u1_q, u0_q, u0_q, {4{pwm_q}},
                                spi_q & s4w_q, spi_q, spi_q, spi_q};
  assign drv = {5'b0, u1_tx, 1'b0, u0_tx, pwm_out, spi_nss, 1'b0, spi_mosi, spi_sck};

  always_comb begin
    logic [NSIG-1:0] rem;
    logic            found;
    rem = act;
    for (int p = 0; p < NPIN; p++) begin
      sel[p] = NONE;
      found  = 1'b0;
      if (!skip_q[p]) begin
        for (int k = 0; k < NSIG; k++) begin
          if (!found && rem[k]) begin
            sel[p] = 4'(k);
            rem[k] = 1'b0;
            found  = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    spi_miso = 1'b0;
    u0_rx    = 1'b1;
    u1_rx    = 1'b1;
    for (int p = 0; p < NPIN; p++) begin
      pin_claimed[p] = (sel[p] != NONE);
      if (pin_claimed[p]) begin
        pad_oe[p]  = IS_OUT[sel[p]];
        pad_out[p] = IS_OUT[sel[p]] & drv[sel[p]];
      end else begin
        pad_oe[p]  = xen_q & gpio_oe[p];
        pad_out[p] = xen_q & gpio_out[p];
      end
      if (sel[p] == SIG_MISO) spi_miso = pad_in[p];
      if (sel[p] == SIG_U0RX) u0_rx    = pad_in[p];
      if (sel[p] == SIG_U1RX) u1_rx    = pad_in[p];
    end
  end

  logic [NPIN-1:0] free_elig, low_free;
  assign free_elig = ~skip_q & ~pin_claimed;
  assign low_free  = free_elig & (~free_elig + 1'b1);

  a_r1_disabled_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !xen_q |-> (pad_oe == '0 && pin_claimed == '0 && u0_rx && u1_rx && !spi_miso));
  a_r3_skip_never_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_claimed & skip_q) == '0);
  a_r3_claims_are_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (free_elig != '0) |-> ((pin_claimed & ~(low_free - 1'b1)) == '0));
  a_r7_claim_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_claimed) <= NSIG);
  a_r8_unclaimed_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    xen_q |-> (((pad_oe ^ gpio_oe) | (pad_out ^ gpio_out)) & ~pin_claimed) == '0);
endmodule

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xen = 0, spi = 0, s4w = 0, pwm = 0, u0 = 0, u1 = 0;
  logic [31:0] skip = '0, gout = '0, goe = '0, pin = '0;
  logic sck = 0, mosi = 0, nss = 0, t0 = 0, t1 = 0;
  logic [3:0] pw = '0;
  logic [31:0] pad_out, pad_oe, claimed;
  logic miso, r0, r1;

  int checks = 0, errors = 0;
  int esel [32];
  logic [31:0] e_out, e_oe, e_cl;
  logic e_miso, e_r0, e_r1;

  always #2.5 clk = ~clk;

  pin_xbar u_pin_xbar (
    .clk(clk), .rst_n(rst_n), .cfg_xbar_en(xen), .cfg_spi_en(spi), .cfg_spi_4w(s4w),
    .cfg_pwm_en(pwm), .cfg_u0_en(u0), .cfg_u1_en(u1), .cfg_skip(skip),
    .gpio_out(gout), .gpio_oe(goe), .pad_in(pin), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_claimed(claimed), .spi_sck(sck), .spi_mosi(mosi), .spi_nss(nss), .spi_miso(miso),
    .pwm_out(pw), .u0_tx(t0), .u0_rx(r0), .u1_tx(t1), .u1_rx(r1));

  function automatic logic sig_is_out(int k);
    return !(k == 2 || k == 9 || k == 11);
  endfunction

  function automatic logic sig_data(int k);
    case (k)
      0: return sck;
      1: return mosi;
      3: return nss;
      4, 5, 6, 7: return pw[k-4];
      8: return t0;
      10: return t1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model();
    int lst [12];
    int n = 0, idx = 0;
    if (spi) begin lst[n] = 0; lst[n+1] = 1; lst[n+2] = 2; n += 3; end
    if (spi && s4w) begin lst[n] = 3; n++; end
    if (pwm) for (int c = 0; c < 4; c++) begin lst[n] = 4 + c; n++; end
    if (u0) begin lst[n] = 8; lst[n+1] = 9; n += 2; end
    if (u1) begin lst[n] = 10; lst[n+1] = 11; n += 2; end
    e_miso = 0; e_r0 = 1; e_r1 = 1;
    for (int p = 0; p < 32; p++) begin
      esel[p] = -1;
      if (xen && !skip[p] && idx < n) begin esel[p] = lst[idx]; idx++; end
      e_cl[p] = esel[p] >= 0;
      if (e_cl[p]) begin
        e_oe[p]  = sig_is_out(esel[p]);
        e_out[p] = sig_is_out(esel[p]) ? sig_data(esel[p]) : 1'b0;
        if (esel[p] == 2)  e_miso = pin[p];
        if (esel[p] == 9)  e_r0   = pin[p];
        if (esel[p] == 11) e_r1   = pin[p];
      end else begin
        e_oe[p]  = xen & goe[p];
        e_out[p] = xen & gout[p];
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    model();
    chk({tag, " claimed"}, claimed, e_cl);
    chk({tag, " pad_oe"}, pad_oe, e_oe);
    chk({tag, " pad_out"}, pad_out, e_out);
    chk({tag, " inputs"}, {29'b0, miso, r0, r1}, {29'b0, e_miso, e_r0, e_r1});
  endtask

  task automatic rand_data();
    gout = $urandom; goe = $urandom; pin = $urandom;
    {sck, mosi, nss, t0, t1} = 5'($urandom);
    pw = 4'($urandom);
  endtask

  task automatic apply_and_check(string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    xen = 1; spi = 1; pwm = 1; u0 = 1; u1 = 1;
    gout = '1; goe = '1; pin = '0;
    repeat (3) @(negedge clk);
    // R1: in reset, pins high-Z and inputs idle
    chk("R1 reset pad_oe", pad_oe, '0);
    chk("R1 reset claimed", claimed, '0);
    chk("R1 reset inputs", {29'b0, miso, r0, r1}, 32'b011);
    rst_n = 1;
    xen = 0;
    apply_and_check("R1 disabled");
    chk("R1 disabled pad_oe", pad_oe, '0);

    // R2: enabled, no peripherals
    spi = 0; pwm = 0; u0 = 0; u1 = 0; xen = 1;
    gout = 32'hA5C3_0F11; goe = 32'h3C3C_F00F;
    apply_and_check("R2 gpio");
    chk("R2 oe follows gpio", pad_oe, goe);

    // R4/R3: skipped gaps splitting the PWM group
    spi = 1; pwm = 1; u0 = 1; u1 = 1; s4w = 0;
    skip = 32'h0000_60FF;
    rand_data();
    apply_and_check("R4 gaps");
    chk("R4 SPI at pins 8..10, PWM 11,12,15,16, UARTs 17..20", claimed, 32'h001F_9F00);

    // R5: 4-wire shifts lower priorities by one
    s4w = 1;
    apply_and_check("R5 four wire");
    chk("R5 claimed grows by one", claimed, 32'h003F_9F00);

    // R7: exhaustion with RX left over
    s4w = 0; skip = ~32'h0000_041F;
    pin = '0;
    apply_and_check("R7 exhaustion");
    chk("R7 rx idle", {30'b0, r0, r1}, 32'b11);

    // R9: config registered
    xen = 1; spi = 1; pwm = 0; u0 = 0; u1 = 0; skip = '0;
    apply_and_check("R9 base");
    @(negedge clk);
    xen = 0;
    #1;
    chk("R9 before edge still claimed", claimed, 32'h7);
    @(negedge clk);
    chk("R9 after edge released", claimed, '0);

    // R3 R4 R6 R8: random sweep
    for (int i = 0; i < 400; i++) begin
      xen = ($urandom % 8) != 0;
      {spi, s4w, pwm, u0, u1} = 5'($urandom);
      case ($urandom % 4)
        0: skip = '0;
        1: skip = $urandom & $urandom;
        2: skip = $urandom;
        default: skip = $urandom | $urandom | $urandom;
      endcase
      rand_data();
      apply_and_check("R6 random");
      rand_data();
      #1;
      check_all("R8 random data");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule